// File: doc/BRIEF.md
# Bit-Field Test-and-Complement Engine

This block carries out one read-modify-write on a single 16-bit destination word, steered by a 16-bit mask that arrives with the command. Each one bit in the mask picks a destination bit. The engine reads the destination and raises a carry flag only if every picked bit reads as one. It then flips the picked bits, leaves all other bits as they were, and writes the word back to the same place.

The destination is either a word in a synchronous memory or an entry in a register file. The command says which one it is. Memory has one-cycle read latency and separate read and write strobes. The register file is read combinationally and written on a clock edge. A host that supplies already-decoded commands issues one command at a time. It watches `busy` and collects the flag when the engine pulses `done`.

Top module: `bitfield_toggle_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `carry` and all four access strobes (`mem_rd_en`, `mem_wr_en`, `reg_rd_en`, `reg_wr_en`) are low.
- R2: `carry` is 1 exactly when (read_value AND mask) equals mask, and 0 otherwise. Example: destination 0x0010 with mask 0x0310 gives carry 0.
- R3: The word written back equals read_value XOR mask, so bits outside the mask are kept. Example: 0x0010 with mask 0x0310 is written back as 0x0300.
- R4: A mask of 0x0000 writes the destination back unchanged and sets `carry` to 1.
- R5: A memory destination (`cmd_is_reg`=0) gets exactly one `mem_rd_en` cycle. The read data is taken one cycle later, and exactly one `mem_wr_en` cycle follows to the same `mem_addr`. `done` is high in the fourth cycle after the accepting edge.
- R6: A register destination (`cmd_is_reg`=1) gets one `reg_rd_en` cycle, with `reg_rdata` taken in that cycle. It gets one `reg_wr_en` cycle in the next cycle to the same `reg_sel`. No memory strobe is issued. `done` is high in the third cycle after the accepting edge.
- R7: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` stays high from the cycle after acceptance through the `done` cycle. Commands presented while `busy` is high are ignored and do not touch any destination.
- R8: `done` is a one-cycle pulse. `carry` is valid during that cycle and holds its value until the next operation captures new read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_is_reg | input | 1 | 1 selects a register destination, 0 selects memory |
| cmd_mask | input | 16 | Bit-selection mask |
| cmd_addr | input | 16 | Memory word address |
| cmd_reg | input | 3 | Register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | All-selected-bits-set flag |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_rd_en` |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_sel | output | 3 | Register index |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid combinationally for `reg_sel` |

## Verification
The assertions assume three things about the environment. `reg_rdata` reflects the entry named by `reg_sel` in the same cycle. `mem_rdata` carries the addressed word in the cycle right after a `mem_rd_en` cycle. Reset is held for at least two clock edges. The bench's memory and register models are built to meet these timings. Its reset lasts several cycles. It drives every command and preload on the falling edge. It also deliberately presents commands while the engine is busy, so that the only uncontrolled input, `cmd_valid`, is exercised against the acceptance rule.

// File: rtl/bftc_pkg.sv
// Package: shared widths and the sequencer state type for the
// bit-field test-and-complement engine. Assumes 16-bit data words.
package bftc_pkg;
    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } bftc_state_e;
endpackage

// File: rtl/bftc_ctrl.sv
// Sequencer: accepts one command when idle and walks the read / wait /
// write / done steps. Memory destinations pass through a wait step for the
// one-cycle read latency; register destinations skip it.
// Assumes cmd_is_reg is only meaningful while cmd_valid is high.
module bftc_ctrl
    import bftc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_is_reg,
    output logic accept,
    output logic cap_mem,
    output logic cap_reg,
    output logic mem_rd_en,
    output logic mem_wr_en,
    output logic reg_rd_en,
    output logic reg_wr_en,
    output logic busy,
    output logic done
);
    bftc_state_e state_q, state_d;
    logic        is_reg_q;

    assign accept = cmd_valid && (state_q == ST_IDLE);

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_READ;
            ST_READ:  state_d = is_reg_q ? ST_WRITE : ST_WAIT;
            ST_WAIT:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and latched destination kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            is_reg_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) is_reg_q <= cmd_is_reg;
        end
    end

    // Strobes and capture enables decoded from the current state.
    always_comb begin
        mem_rd_en = (state_q == ST_READ)  && !is_reg_q;
        reg_rd_en = (state_q == ST_READ)  &&  is_reg_q;
        cap_reg   = (state_q == ST_READ)  &&  is_reg_q;
        cap_mem   = (state_q == ST_WAIT);
        mem_wr_en = (state_q == ST_WRITE) && !is_reg_q;
        reg_wr_en = (state_q == ST_WRITE) &&  is_reg_q;
        done      = (state_q == ST_DONE);
        busy      = (state_q != ST_IDLE);
    end

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_write_two_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2));
    a_r6_reg_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ($past(reg_rd_en) && !mem_rd_en && !mem_wr_en));
    a_r7_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/bftc_datapath.sv
// Datapath: latches the command's mask and destination on acceptance,
// captures the destination word from whichever source the sequencer names,
// forms the all-selected-set flag and the complemented word.
// Assumes cap_mem and cap_reg are never high together.
module bftc_datapath #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] cmd_mask,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic              cap_mem,
    input  logic              cap_reg,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [REG_W-1:0]  reg_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] hit;
    logic              all_set;
    logic              carry_q;

    // Pick the word being captured this cycle.
    assign src = cap_mem ? mem_rdata : reg_rdata;

    // Per-bit test: an unselected bit always passes.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit_test
        assign hit[i] = ~mask_q[i] | src[i];
    end
    assign all_set = &hit;

    // Command latch and read-data capture with flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            reg_q   <= '0;
            mask_q  <= '0;
            word_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= cmd_addr;
                reg_q  <= cmd_reg;
                mask_q <= cmd_mask;
            end
            if (cap_mem || cap_reg) begin
                word_q  <= src;
                carry_q <= all_set;
            end
        end
    end

    assign result = word_q ^ mask_q;
    assign carry  = carry_q;

    a_r8_carry_stable_between_captures: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_mem || cap_reg) |-> $stable(carry_q));
endmodule

// File: rtl/bitfield_toggle_engine.sv
// Top: bit-field test-and-complement engine. Reads one 16-bit destination
// (memory word or register), flags whether every masked bit is set, flips
// the masked bits and writes the word back.
// Assumes: mem_rdata valid one cycle after mem_rd_en; reg_rdata is a
// combinational read of reg_sel; reset held for at least two edges.
module bitfield_toggle_engine
    import bftc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_reg,
    input  logic [WORD_W-1:0] cmd_mask,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [REG_W-1:0]  cmd_reg,
    output logic              busy,
    output logic              done,
    output logic              carry,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [REG_W-1:0]  reg_sel,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic              accept;
    logic              cap_mem;
    logic              cap_reg;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] result;

    bftc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_is_reg(cmd_is_reg),
        .accept    (accept),
        .cap_mem   (cap_mem),
        .cap_reg   (cap_reg),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_wr_en (reg_wr_en),
        .busy      (busy),
        .done      (done)
    );

    bftc_datapath #(
        .DATA_W(WORD_W),
        .ADDR_W(ADDR_W),
        .REG_W (REG_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cmd_mask (cmd_mask),
        .cmd_addr (cmd_addr),
        .cmd_reg  (cmd_reg),
        .cap_mem  (cap_mem),
        .cap_reg  (cap_reg),
        .mem_rdata(mem_rdata),
        .reg_rdata(reg_rdata),
        .addr_q   (mem_addr),
        .reg_q    (reg_sel),
        .mask_q   (mask_q),
        .result   (result),
        .carry    (carry)
    );

    assign mem_wdata = result;
    assign reg_wdata = result;

    a_r1_one_access_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en, reg_rd_en, reg_wr_en}));
    a_r5_same_mem_address: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr == $past(mem_addr, 2)));
    a_r3_reg_flip_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ((reg_wdata ^ $past(reg_rdata)) == mask_q));
    a_r4_empty_mask_sets_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mask_q == '0)) |-> carry);
    a_r7_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(mask_q));
endmodule

// File: tb/sim_bitfield_toggle_engine.sv
// Bench: fixed-seed random and directed operations on a model memory and
// register file, checked against bench-computed expectations.
module sim_bitfield_toggle_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_reg = 1'b0;
    logic [15:0] cmd_mask = '0;
    logic [15:0] cmd_addr = '0;
    logic [2:0]  cmd_reg = '0;
    logic        busy, done, carry;
    logic        mem_rd_en, mem_wr_en, reg_rd_en, reg_wr_en;
    logic [15:0] mem_addr, mem_wdata, reg_wdata, reg_rdata;
    logic [15:0] mem_rdata = '0;
    logic [2:0]  reg_sel;

    logic [15:0] mem [16];
    logic [15:0] regs [8];
    logic        pl_we = 1'b0;
    logic        pl_reg = 1'b0;
    logic [3:0]  pl_idx = '0;
    logic [15:0] pl_val = '0;

    int checks = 0;
    int errors = 0;
    int n_mrd, n_mwr, n_rrd, n_rwr;

    always #10 clk = ~clk;

    bitfield_toggle_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_reg(cmd_is_reg),
        .cmd_mask(cmd_mask), .cmd_addr(cmd_addr), .cmd_reg(cmd_reg),
        .busy(busy), .done(done), .carry(carry),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_sel];

    // Storage models, preload port and strobe counters.
    always @(posedge clk) begin
        if (mem_rd_en) begin mem_rdata <= mem[mem_addr[3:0]]; n_mrd <= n_mrd + 1; end
        if (mem_wr_en) begin mem[mem_addr[3:0]] <= mem_wdata; n_mwr <= n_mwr + 1; end
        if (reg_rd_en) n_rrd <= n_rrd + 1;
        if (reg_wr_en) begin regs[reg_sel] <= reg_wdata; n_rwr <= n_rwr + 1; end
        if (pl_we) begin
            if (pl_reg) regs[pl_idx[2:0]] <= pl_val;
            else        mem[pl_idx] <= pl_val;
        end
    end

    function automatic logic f_carry(input logic [15:0] d, input logic [15:0] m);
        return (d & m) == m;
    endfunction
    function automatic logic [15:0] f_value(input logic [15:0] d, input logic [15:0] m);
        return d ^ m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic is_reg, input int idx, input logic [15:0] v);
        @(negedge clk);
        pl_we = 1'b1; pl_reg = is_reg; pl_idx = idx[3:0]; pl_val = v;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    function automatic logic [15:0] peek(input logic is_reg, input int idx);
        return is_reg ? regs[idx[2:0]] : mem[idx[3:0]];
    endfunction

    // One operation; optional intrusive command while busy; full checking.
    task automatic run_op(input logic is_reg, input int idx, input logic [15:0] mask,
                          input logic [15:0] init, input logic intrude);
        int n;
        int other;
        logic [15:0] other_val;
        logic exp_c;
        other = (idx + 1) % (is_reg ? 8 : 16);
        preload(is_reg, idx, init);
        other_val = peek(is_reg, other);
        n_mrd = 0; n_mwr = 0; n_rrd = 0; n_rwr = 0;
        exp_c = f_carry(init, mask);
        cmd_valid = 1'b1; cmd_is_reg = is_reg; cmd_mask = mask;
        cmd_addr = 16'(idx); cmd_reg = 3'(idx);
        @(negedge clk);
        n = 1;
        check("R7 busy after accept", busy, 1'b1);
        if (intrude) begin
            cmd_mask = ~mask; cmd_addr = 16'(other); cmd_reg = 3'(other);
        end else begin
            cmd_valid = 1'b0;
        end
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
            if (!done) check("R7 busy held", busy, 1'b1);
        end
        cmd_valid = 1'b0;
        check(is_reg ? "R6 done latency" : "R5 done latency", n, is_reg ? 3 : 4);
        check("R2 carry", carry, exp_c);
        check("R3 written value", peek(is_reg, idx), f_value(init, mask));
        if (is_reg) begin
            check("R6 reg reads", n_rrd, 1); check("R6 reg writes", n_rwr, 1);
            check("R6 no mem strobes", n_mrd + n_mwr, 0);
        end else begin
            check("R5 mem reads", n_mrd, 1); check("R5 mem writes", n_mwr, 1);
            check("R5 no reg strobes", n_rrd + n_rwr, 0);
        end
        if (intrude) check("R7 ignored command target untouched", peek(is_reg, other), other_val);
        @(negedge clk);
        check("R8 done one cycle", done, 1'b0);
        check("R8 carry held", carry, exp_c);
        check("R7 idle after done", busy, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        n_mrd = 0; n_mwr = 0; n_rrd = 0; n_rwr = 0;
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        for (int i = 0; i < 8; i++) regs[i] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 reset busy", busy, 1'b0);
        check("R1 reset done", done, 1'b0);
        check("R1 reset carry", carry, 1'b0);
        check("R1 reset strobes", {mem_rd_en, mem_wr_en, reg_rd_en, reg_wr_en}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset idle", {busy, done, mem_rd_en, reg_rd_en}, 4'b0);

        // Worked example, both destination kinds (R2, R3).
        run_op(1'b0, 2, 16'h0310, 16'h0010, 1'b0);
        run_op(1'b1, 5, 16'h0310, 16'h0010, 1'b0);
        // Empty mask (R4): unchanged, carry set.
        run_op(1'b0, 7, 16'h0000, 16'hA5C3, 1'b0);
        check("R4 empty mask unchanged", mem[7], 16'hA5C3);
        check("R4 empty mask carry", carry, 1'b1);
        run_op(1'b1, 3, 16'h0000, 16'h1234, 1'b0);
        check("R4 empty mask reg unchanged", regs[3], 16'h1234);
        // All-ones mask, set and not-set cases.
        run_op(1'b0, 9, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(1'b1, 0, 16'hFFFF, 16'hFFFE, 1'b0);
        // Ignored commands while busy (R7).
        run_op(1'b0, 4, 16'h00F0, 16'h00F0, 1'b1);
        run_op(1'b1, 6, 16'h8001, 16'h8000, 1'b1);

        // Constrained random: half the data forced to cover the mask.
        for (int k = 0; k < 60; k++) begin
            logic [15:0] m, d;
            logic is_reg;
            int idx;
            is_reg = $urandom_range(0, 1) == 1;
            idx = is_reg ? $urandom_range(0, 7) : $urandom_range(0, 15);
            m = 16'($urandom);
            d = 16'($urandom);
            if ($urandom_range(0, 1) == 1) d = d | m;
            run_op(is_reg, idx, m, d, $urandom_range(0, 3) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule